// File: doc/BRIEF.md
# Triggered Pipeline Cell Allocator

This block steers writes into a ring of 192 analogue sample cells and protects the cells that belong to triggered events. A write pointer moves on by one cell every clock. When a trigger arrives, the block takes the cell that lies a programmable latency behind the write pointer and the two cells after it as the event's group. It holds those three cells so they cannot be overwritten, and queues the group in a 16-entry FIFO.

A readout side works independently of triggers. It sees the oldest queued group's three cell addresses and pops the group when it has read them, which releases the cells. The write pointer always steps to the next cell, in ring order, that no queued group holds.

Groups may overlap when triggers come close together. A cell therefore keeps a count of the queued groups that hold it, and becomes free only when that count returns to zero.

Top module: `pipe_cell_alloc`

## Requirements
- R1: While reset is asserted, and after it is released, the write pointer is cell 0, the FIFO is empty (`rd_valid` low, `full` low), `ovf` is low and no cell is held.
- R2: With no held cells ahead of it, `wr_cell` advances by one every clock and wraps from 191 to 0.
- R3: An accepted trigger queues a group whose first cell is (`wr_cell` − latency) mod 192 at the trigger's clock edge. `rd_cell1` and `rd_cell2` are the next two cells, mod 192.
- R4: The effective latency is `lat_cfg` clamped to the range 3 to 160. Values below 3 act as 3, and values above 160 act as 160.
- R5: `rd_valid` is high exactly when the FIFO is not empty, and `rd_cell0..2` show the oldest group. A pop with `rd_valid` high removes that group. A pop while empty has no effect.
- R6: The FIFO holds up to 16 groups, and `full` is high exactly at 16. A trigger while full is dropped: it queues nothing, holds no cell and sets `ovf`. `ovf` then stays high until reset.
- R7: On each clock the write pointer moves to the first cell after its current one, in ring order, that is not held once that clock's trigger and pop have taken effect.
- R8: A pop releases its three cells on the same clock, so the write pointer may land on them at that very edge.
- R9: A cell held by several queued groups stays held until every group holding it has been popped.
- R10: A trigger and a pop on the same clock both take effect. Fullness for dropping a trigger is judged on the count before that clock's pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig | input | 1 | Trigger, one group per clock it is high |
| lat_cfg | input | 8 | Requested latency in cells |
| rd_pop | input | 1 | Readout pops the oldest group |
| rd_valid | output | 1 | FIFO holds at least one group |
| rd_cell0 | output | 8 | First cell of the oldest group |
| rd_cell1 | output | 8 | Second cell of the oldest group |
| rd_cell2 | output | 8 | Third cell of the oldest group |
| wr_cell | output | 8 | Cell being written this clock |
| full | output | 1 | FIFO holds 16 groups |
| ovf | output | 1 | Sticky flag: a trigger was dropped |

## Verification
The bench first fills the FIFO with back-to-back triggers, which makes the groups overlap by two cells. If the design freed cells on the first pop instead of counting holders, the write pointer would land early on a cell still queued. If it miscounted fullness, it would accept a 17th group or fail to set `ovf`. The bench then lets the pointer run through held cells and pops slowly. A design that skipped using stale held bits, or that released cells a clock late, would show a `wr_cell` one step off the model. A long mixed run drives triggers, pops and out-of-range latencies on the same clocks, including pops while empty; a missing clamp shows up as the wrong first cell of a group.

// File: rtl/pipe_cell_alloc.sv
module pipe_cell_alloc #(
  parameter int NCELLS  = 192,
  parameter int FDEPTH  = 16,
  parameter int LAT_MIN = 3,
  parameter int LAT_MAX = 160,
  parameter int LW      = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       trig,
  input  logic [LW-1:0]              lat_cfg,
  input  logic                       rd_pop,
  output logic                       rd_valid,
  output logic [$clog2(NCELLS)-1:0]  rd_cell0,
  output logic [$clog2(NCELLS)-1:0]  rd_cell1,
  output logic [$clog2(NCELLS)-1:0]  rd_cell2,
  output logic [$clog2(NCELLS)-1:0]  wr_cell,
  output logic                       full,
  output logic                       ovf
);
  localparam int AW = $clog2(NCELLS);
  localparam int FW = $clog2(FDEPTH);
  localparam int CW = $clog2(FDEPTH + 1);

  function automatic logic [AW-1:0] ring_add(input int a, input int b);
    int s;
    s = a + b;
    if (s >= NCELLS) s = s - NCELLS;
    return AW'(s);
  endfunction

  logic [AW-1:0] wp, wp_nxt;
  logic [CW-1:0] hold [NCELLS];
  logic [CW-1:0] hold_nxt [NCELLS];
  logic [AW-1:0] fbase [FDEPTH];
  logic [FW-1:0] rptr, wptr;
  logic [CW-1:0] fcnt;
  logic          ovf_q;

  logic [LW-1:0] lat_eff;
  logic [AW-1:0] g0, g1, g2, h0, h1, h2;
  logic          accept, pop_ok;

  assign lat_eff = (int'(lat_cfg) < LAT_MIN) ? LW'(LAT_MIN) :
                   (int'(lat_cfg) > LAT_MAX) ? LW'(LAT_MAX) : lat_cfg;

  assign accept = trig && (int'(fcnt) != FDEPTH);
  assign pop_ok = rd_pop && (fcnt != '0);

  assign g0 = ring_add(int'(wp), NCELLS - int'(lat_eff));
  assign g1 = ring_add(int'(g0), 1);
  assign g2 = ring_add(int'(g0), 2);
  assign h0 = fbase[rptr];
  assign h1 = ring_add(int'(h0), 1);
  assign h2 = ring_add(int'(h0), 2);

  always_comb begin
    for (int c = 0; c < NCELLS; c++) begin
      logic inc, dec;
      inc = accept && (AW'(c) == g0 || AW'(c) == g1 || AW'(c) == g2);
      dec = pop_ok && (AW'(c) == h0 || AW'(c) == h1 || AW'(c) == h2);
      hold_nxt[c] = hold[c] + CW'(inc) - CW'(dec);
    end
  end

  always_comb begin
    logic found;
    logic [AW-1:0] idx;
    found  = 1'b0;
    wp_nxt = wp;
    for (int i = 1; i < NCELLS; i++) begin
      idx = ring_add(int'(wp), i);
      if (!found && hold_nxt[idx] == '0) begin
        wp_nxt = idx;
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rptr  <= '0;
      wptr  <= '0;
      fcnt  <= '0;
      ovf_q <= 1'b0;
      for (int c = 0; c < NCELLS; c++) hold[c] <= '0;
    end else begin
      wp <= wp_nxt;
      for (int c = 0; c < NCELLS; c++) hold[c] <= hold_nxt[c];
      if (trig && !accept) ovf_q <= 1'b1;
      if (accept) begin
        fbase[wptr] <= g0;
        wptr <= (int'(wptr) == FDEPTH - 1) ? '0 : wptr + 1'b1;
      end
      if (pop_ok) rptr <= (int'(rptr) == FDEPTH - 1) ? '0 : rptr + 1'b1;
      fcnt <= fcnt + CW'(accept) - CW'(pop_ok);
    end
  end

  assign wr_cell  = wp;
  assign rd_valid = (fcnt != '0);
  assign rd_cell0 = h0;
  assign rd_cell1 = h1;
  assign rd_cell2 = h2;
  assign full     = (int'(fcnt) == FDEPTH);
  assign ovf      = ovf_q;
endmodule

module pipe_cell_alloc_chk #(
  parameter int NCELLS = 192,
  parameter int AW     = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trig,
  input logic          rd_pop,
  input logic          rd_valid,
  input logic [AW-1:0] rd_cell0,
  input logic [AW-1:0] rd_cell2,
  input logic [AW-1:0] wr_cell,
  input logic          full,
  input logic          ovf
);
  p_wr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wr_cell) < NCELLS);
  p_wr_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> wr_cell != $past(wr_cell));
  p_group_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> int'(rd_cell2) == ((int'(rd_cell0) + 2) % NCELLS));
  p_full_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> rd_valid);
  p_drop_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full && trig |=> ovf);
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  p_pop_unfills_r10: assert property (@(posedge clk) disable iff (!rst_n)
    full && rd_pop |=> !full);
endmodule

bind pipe_cell_alloc pipe_cell_alloc_chk #(.NCELLS(NCELLS), .AW($clog2(NCELLS))) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .rd_pop(rd_pop), .rd_valid(rd_valid),
  .rd_cell0(rd_cell0), .rd_cell2(rd_cell2), .wr_cell(wr_cell), .full(full), .ovf(ovf)
);

// File: tb/sim_pipe_cell_alloc.sv
`timescale 1ns/1ps
module sim_pipe_cell_alloc;
  localparam int N = 192;
  localparam int D = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, trig, rd_pop;
  logic [7:0] lat_cfg;
  logic       rd_valid, full, ovf;
  logic [7:0] rd_cell0, rd_cell1, rd_cell2, wr_cell;

  pipe_cell_alloc u0 (
    .clk(clk), .rst_n(rst_n), .trig(trig), .lat_cfg(lat_cfg), .rd_pop(rd_pop),
    .rd_valid(rd_valid), .rd_cell0(rd_cell0), .rd_cell1(rd_cell1), .rd_cell2(rd_cell2),
    .wr_cell(wr_cell), .full(full), .ovf(ovf)
  );

  int    n_chk = 0, n_fail = 0;
  string phase = "R1";
  bit    cmp_en = 0;
  bit    done = 0;

  int m_hold [N];
  int m_q [$];
  int m_wp;
  bit m_ovf;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s (phase %s) actual=%0d expected=%0d", tag, phase, act, exp);
    end
  endtask

  function automatic int clamp_lat(int l);
    if (l < 3) return 3;
    if (l > 160) return 160;
    return l;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < N; c++) m_hold[c] = 0;
      m_q.delete();
      m_wp = 0;
      m_ovf = 0;
    end else begin
      bit acc, pp;
      acc = trig && (m_q.size() < D);
      pp  = rd_pop && (m_q.size() > 0);
      if (trig && !acc) m_ovf = 1;
      if (acc) begin
        int b;
        b = (m_wp + N - clamp_lat(int'(lat_cfg))) % N;
        for (int k = 0; k < 3; k++) m_hold[(b + k) % N]++;
        m_q.push_back(b);
      end
      if (pp) begin
        int h;
        h = m_q.pop_front();
        for (int k = 0; k < 3; k++) m_hold[(h + k) % N]--;
      end
      for (int i = 1; i < N; i++) begin
        if (m_hold[(m_wp + i) % N] == 0) begin
          m_wp = (m_wp + i) % N;
          break;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk("R2/R7/R8/R9 wr_cell", int'(wr_cell), m_wp);
      chk("R5 rd_valid", int'(rd_valid), int'(m_q.size() > 0));
      if (m_q.size() > 0) begin
        chk("R3 rd_cell0", int'(rd_cell0), m_q[0]);
        chk("R3 rd_cell1", int'(rd_cell1), (m_q[0] + 1) % N);
        chk("R3 rd_cell2", int'(rd_cell2), (m_q[0] + 2) % N);
      end
      chk("R6 full", int'(full), int'(m_q.size() == D));
      chk("R6 ovf", int'(ovf), int'(m_ovf));
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reset_check();
    rst_n = 0; trig = 0; rd_pop = 0; lat_cfg = 8'd10;
    cmp_en = 0;
    idle(3);
    phase = "R1";
    chk("R1 wr_cell in reset", int'(wr_cell), 0);
    chk("R1 rd_valid in reset", int'(rd_valid), 0);
    chk("R1 full in reset", int'(full), 0);
    chk("R1 ovf in reset", int'(ovf), 0);
    rst_n = 1;
    cmp_en = 1;
    @(negedge clk);
    chk("R1 wr_cell one clock after reset", int'(wr_cell), 1);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired (phase %s) actual=running expected=done", phase);
      finish_up();
    end
  end

  initial begin
    int w;
    reset_check();

    phase = "R2";
    idle(200);

    phase = "R3";
    w = int'(wr_cell); lat_cfg = 8'd10; trig = 1;
    @(negedge clk); trig = 0;
    chk("R3 first cell of group", int'(rd_cell0), (w + N - 10) % N);
    idle(5);
    rd_pop = 1; @(negedge clk); rd_pop = 0;
    chk("R5 empty after pop", int'(rd_valid), 0);
    rd_pop = 1; idle(2); rd_pop = 0;
    chk("R5 pop while empty", int'(rd_valid), 0);

    phase = "R4";
    w = int'(wr_cell); lat_cfg = 8'd0; trig = 1;
    @(negedge clk); trig = 0;
    chk("R4 low clamp", int'(rd_cell0), (w + N - 3) % N);
    rd_pop = 1; @(negedge clk); rd_pop = 0;
    w = int'(wr_cell); lat_cfg = 8'd255; trig = 1;
    @(negedge clk); trig = 0;
    chk("R4 high clamp", int'(rd_cell0), (w + N - 160) % N);
    rd_pop = 1; @(negedge clk); rd_pop = 0;

    phase = "R6/R9";
    lat_cfg = 8'd20;
    trig = 1; idle(D); 
    chk("R6 full at sixteen", int'(full), 1);
    chk("R6 no overflow yet", int'(ovf), 0);
    @(negedge clk); trig = 0;
    chk("R6 drop sets ovf", int'(ovf), 1);
    chk("R6 still full after drop", int'(full), 1);

    phase = "R7";
    idle(250);

    phase = "R8";
    for (int k = 0; k < D; k++) begin
      rd_pop = 1; @(negedge clk); rd_pop = 0;
      idle(7);
    end
    chk("R8 FIFO drained", int'(rd_valid), 0);
    chk("R6 ovf sticky", int'(ovf), 1);

    phase = "R10";
    for (int i = 0; i < 6000; i++) begin
      trig    = ($urandom % 100) < 30;
      rd_pop  = ($urandom % 100) < 28;
      lat_cfg = 8'($urandom % 256);
      @(negedge clk);
    end
    trig = 1; rd_pop = 1; lat_cfg = 8'd50;
    idle(40);
    trig = 0; rd_pop = 0;
    idle(20);

    reset_check();
    chk("R1 ovf cleared by reset", int'(ovf), 0);
    idle(10);

    done = 1;
    finish_up();
  end
endmodule